// File: doc/BRIEF.md
# Key-Locked System Control Register Bank

This block is a small bank of status and control words on a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and read data. Reads are combinational from the address. Writes take effect on the rising clock edge while the strobe is high.

The bank holds the following:
- an identity word built from parameters;
- an LED output register;
- a lock word that guards a reset-level register;
- a volatile flags word and a non-volatile flags word, each with its own set address and clear address;
- a display control word whose bits 13:8 are read-only and whose two low bits drive a mux-select output;
- a card-status word fed from two input pins.

An accepted write to the reset-level register may raise a one-cycle system-reset request. A parameter selects board variant A or B. The variant moves the bit that triggers the reset request and the bit position of the write-protect status.

Software first writes the unlock key to the lock word and then writes the reset-level register. Any other write to the lock word re-locks the bank.

Top module: `sysreg_bank`

## Requirements
- R1: After reset the LED, lock, flags and reset-level words read 0, the display word reads 0x1F00, `led_o` and `mux_sel_o` are 0, and `sys_rst_req_o` is low.
- R2: A write to offset 0x20 of exactly 0x0000A05F stores 0xA05F. Any other write stores its low 16 bits ANDed with 0x7FFF. The word reads back zero-extended.
- R3: A write to offset 0x40 is stored only while the lock word equals 0xA05F. Otherwise the write leaves the reset-level word unchanged. The stored word reads back at offset 0x40.
- R4: An accepted offset-0x40 write whose data has the trigger bit set raises `sys_rst_req_o` for exactly the one cycle after the write edge. The trigger bit is bit 8 for variant A and bit 2 for variant B. No other write raises it.
- R5: A write to 0x30 ORs the data into the flags word. A write to 0x34 clears the data's set bits. The word reads at 0x30, and 0x34 reads 0.
- R6: The non-volatile flags word works the same way, with set at 0x38 and clear at 0x3C, and reads at 0x38. Its contents survive an assertion of `rst_n`.
- R7: A write to offset 0x50 replaces all of bits 15:0 except bits 13:8, which keep 0x1F. `mux_sel_o` equals bits 1:0 of the stored word.
- R8: Offset 0x48 reads the card-detect input in bit 0. It reads the write-protect input in bit 2 for variant A and in bit 1 for variant B. Both are sampled on the clock edge, and all other bits read 0.
- R9: Offset 0x00 reads {4'h0, BOARD_CODE, ID_REV}, so the board code sits in bits 27:16. Writes to it are ignored.
- R10: Offset 0x44 always reads 1. Offset 0x04 and every unmapped offset read 0. Writes to any of them change no register.
- R11: Offset 0x08 is a read/write LED word of `LED_W` bits that drives `led_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| card_detect_i | input | 1 | Card present status pin |
| card_wprot_i | input | 1 | Card write-protect status pin |
| led_o | output | LED_W | LED drive |
| mux_sel_o | output | 2 | Display format mux select |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The following behaviours are checked on every cycle:
- the reset request lasts one cycle and only follows an unlocked trigger write;
- a locked write leaves the reset-level word unchanged;
- a bad key drops the unlock state;
- set and clear writes on both flag words behave as specified;
- the read-only display field stays fixed and the mux output follows the written bits.

Other behaviours only show in the bench's scenarios. These are the read-back values at each offset, the two variants' different trigger and write-protect bits, the exact lock values stored for near-miss keys, and the non-volatile word surviving reset.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_IDENT   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_SWITCH  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_LED     = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_FL_SET  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_FL_CLR  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_NV_SET  = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_NV_CLR  = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_RSTLVL  = 12'h040;
  localparam logic [ADDR_W-1:0] OFS_FIXED1  = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_CARD    = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_DISP    = 12'h050;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [15:0] LOCK_MASK  = 16'h7FFF;

  typedef enum logic {VAR_A = 1'b0, VAR_B = 1'b1} board_var_e;

  function automatic int unsigned trig_bit(board_var_e v);
    return (v == VAR_A) ? 8 : 2;
  endfunction

  function automatic int unsigned wprot_bit(board_var_e v);
    return (v == VAR_A) ? 2 : 1;
  endfunction

endpackage

// File: rtl/sysreg_lock.sv
module sysreg_lock
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [15:0]       lock_o,
  output logic              unlocked_o
);

  logic [15:0] lock_q, lock_d;
  logic        key_match;

  assign key_match = (wdata == {{(DATA_W-16){1'b0}}, UNLOCK_KEY});

  always_comb begin
    lock_d = lock_q;
    if (wr_en) begin
      lock_d = key_match ? UNLOCK_KEY : (wdata[15:0] & LOCK_MASK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  assign lock_o     = lock_q;
  assign unlocked_o = (lock_q == UNLOCK_KEY);

  // R2: any write other than the exact key leaves the bank locked
  p_bad_key_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_match) |=> !unlocked_o);

  // R2: the exact key unlocks on the next cycle
  p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key_match) |=> unlocked_o);

endmodule

// File: rtl/sysreg_flags.sv
module sysreg_flags #(
  parameter int unsigned W             = 32,
  parameter bit          KEEP_ON_RESET = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (set_en) d = d | wdata;
    if (clr_en) d = d & ~wdata;
  end

  generate
    if (KEEP_ON_RESET) begin : g_retained
      always_ff @(posedge clk) begin
        q <= d;
      end
    end else begin : g_cleared
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end
  endgenerate

  assign q_o = q;

  // R5/R6: set writes leave every written one set
  p_set_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q_o & $past(wdata)) == $past(wdata)));

  // R5/R6: clear writes leave every written one cleared
  p_clr_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((q_o & $past(wdata)) == '0));

endmodule

// File: rtl/sysreg_rstctl.sv
module sysreg_rstctl
  import sysreg_pkg::*;
#(
  parameter board_var_e VARIANT = VAR_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] level_o,
  output logic              req_o
);

  localparam int unsigned TRIG = trig_bit(VARIANT);

  logic [DATA_W-1:0] level_q, level_d;
  logic              req_q, req_d;
  logic              accept;

  assign accept = wr_en & unlocked_i;

  always_comb begin
    level_d = level_q;
    req_d   = 1'b0;
    if (accept) begin
      level_d = wdata;
      req_d   = wdata[TRIG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      req_q   <= req_d;
    end
  end

  assign level_o = level_q;
  assign req_o   = req_q;

  // R3: a locked write leaves the level unchanged
  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlocked_i) |=> $stable(level_o));

  // R4: request lasts a single cycle
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R4: request only after an unlocked trigger write
  p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(wr_en && unlocked_i && wdata[TRIG]));

endmodule

// File: rtl/sysreg_display.sv
module sysreg_display #(
  parameter int unsigned W        = 16,
  parameter int unsigned RO_LSB   = 8,
  parameter int unsigned RO_MSB   = 13,
  parameter logic [W-1:0] RST_VAL = 16'h1F00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o,
  output logic [1:0]   mux_sel_o
);

  localparam int unsigned RO_BITS = RO_MSB - RO_LSB + 1;
  localparam logic [W-1:0] RO_MASK = W'(((64'd1 << RO_BITS) - 64'd1) << RO_LSB);

  logic [W-1:0] q, d;

  always_comb begin
    d = q;
    if (wr_en) d = (q & RO_MASK) | (wdata & ~RO_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end

  assign q_o       = q;
  assign mux_sel_o = q[1:0];

  // R7: the read-only field keeps its reset value
  p_ro_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    q_o[RO_MSB:RO_LSB] == RST_VAL[RO_MSB:RO_LSB]);

  // R7: mux select follows the written low bits
  p_mux_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mux_sel_o == $past(wdata[1:0])));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter board_var_e  VARIANT    = VAR_A,
  parameter logic [11:0] BOARD_CODE = 12'h0A5,
  parameter logic [15:0] ID_REV     = 16'h0101,
  parameter int unsigned LED_W      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        card_detect_i,
  input  logic        card_wprot_i,
  output logic [LED_W-1:0] led_o,
  output logic [1:0]  mux_sel_o,
  output logic        sys_rst_req_o
);

  localparam int unsigned WP_BIT = wprot_bit(VARIANT);
  localparam int unsigned DISP_W = 16;

  // write decode
  logic we_led, we_lock, we_fset, we_fclr, we_nset, we_nclr, we_rst, we_disp;

  always_comb begin
    we_led  = bus_wr && (bus_addr == OFS_LED);
    we_lock = bus_wr && (bus_addr == OFS_LOCK);
    we_fset = bus_wr && (bus_addr == OFS_FL_SET);
    we_fclr = bus_wr && (bus_addr == OFS_FL_CLR);
    we_nset = bus_wr && (bus_addr == OFS_NV_SET);
    we_nclr = bus_wr && (bus_addr == OFS_NV_CLR);
    we_rst  = bus_wr && (bus_addr == OFS_RSTLVL);
    we_disp = bus_wr && (bus_addr == OFS_DISP);
  end

  // LED word
  logic [LED_W-1:0] led_q, led_d;

  always_comb begin
    led_d = led_q;
    if (we_led) led_d = bus_wdata[LED_W-1:0];
  end

  // card status sampling
  logic [1:0] card_q, card_d;

  always_comb begin
    card_d = {card_wprot_i, card_detect_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q  <= '0;
      card_q <= '0;
    end else begin
      led_q  <= led_d;
      card_q <= card_d;
    end
  end

  // sub-blocks
  logic [15:0]       lock_val;
  logic              unlocked;
  logic [31:0]       flags_val, nvflags_val, level_val;
  logic [DISP_W-1:0] disp_val;

  sysreg_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (we_lock),
    .wdata      (bus_wdata),
    .lock_o     (lock_val),
    .unlocked_o (unlocked)
  );

  sysreg_flags #(.W(32), .KEEP_ON_RESET(1'b0)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (we_fset),
    .clr_en (we_fclr),
    .wdata  (bus_wdata),
    .q_o    (flags_val)
  );

  sysreg_flags #(.W(32), .KEEP_ON_RESET(1'b1)) u_nvflags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (we_nset),
    .clr_en (we_nclr),
    .wdata  (bus_wdata),
    .q_o    (nvflags_val)
  );

  sysreg_rstctl #(.VARIANT(VARIANT)) u_rstctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (we_rst),
    .unlocked_i (unlocked),
    .wdata      (bus_wdata),
    .level_o    (level_val),
    .req_o      (sys_rst_req_o)
  );

  sysreg_display #(.W(DISP_W), .RO_LSB(8), .RO_MSB(13), .RST_VAL(16'h1F00)) u_disp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (we_disp),
    .wdata     (bus_wdata[DISP_W-1:0]),
    .q_o       (disp_val),
    .mux_sel_o (mux_sel_o)
  );

  // read mux
  logic [31:0] card_word;

  always_comb begin
    card_word         = '0;
    card_word[0]      = card_q[0];
    card_word[WP_BIT] = card_q[1];
  end

  always_comb begin
    case (bus_addr)
      OFS_IDENT:  bus_rdata = {4'h0, BOARD_CODE, ID_REV};
      OFS_LED:    bus_rdata = 32'(led_q);
      OFS_LOCK:   bus_rdata = {16'h0, lock_val};
      OFS_FL_SET: bus_rdata = flags_val;
      OFS_NV_SET: bus_rdata = nvflags_val;
      OFS_RSTLVL: bus_rdata = level_val;
      OFS_FIXED1: bus_rdata = 32'd1;
      OFS_CARD:   bus_rdata = card_word;
      OFS_DISP:   bus_rdata = {16'h0, disp_val};
      default:    bus_rdata = '0;
    endcase
  end

  assign led_o = led_q;

  // R11: LED output follows an LED write
  p_led_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    we_led |=> (led_o == $past(bus_wdata[LED_W-1:0])));

  // R8: card word tracks the pins one cycle later
  p_card_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CARD) |-> (bus_rdata[0] == card_q[0]));

endmodule

// File: tb/sim_sysreg_bank.sv
module sim_sysreg_bank;
  import sysreg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        card_det, card_wp;
  logic [31:0] rd_a, rd_b;
  logic [7:0]  led_a, led_b;
  logic [1:0]  mux_a, mux_b;
  logic        req_a, req_b;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sysreg_bank #(.VARIANT(VAR_A), .BOARD_CODE(12'h0A5), .ID_REV(16'h0101), .LED_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_a), .card_detect_i(card_det), .card_wprot_i(card_wp),
    .led_o(led_a), .mux_sel_o(mux_a), .sys_rst_req_o(req_a));

  sysreg_bank #(.VARIANT(VAR_B), .BOARD_CODE(12'h0A5), .ID_REV(16'h0101), .LED_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(rd_b), .card_detect_i(card_det), .card_wprot_i(card_wp),
    .led_o(led_b), .mux_sel_o(mux_b), .sys_rst_req_o(req_b));

  // reference model
  logic [7:0]  m_led;
  logic [15:0] m_lock;
  logic [31:0] m_flags, m_nv, m_level;
  logic [15:0] m_disp;
  logic [1:0]  m_card;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a, input bit var_b);
    logic [31:0] c;
    c = '0;
    c[0] = m_card[0];
    if (var_b) c[1] = m_card[1]; else c[2] = m_card[1];
    case (a)
      12'h000: return {4'h0, 12'h0A5, 16'h0101};
      12'h008: return {24'h0, m_led};
      12'h020: return {16'h0, m_lock};
      12'h030: return m_flags;
      12'h038: return m_nv;
      12'h040: return m_level;
      12'h044: return 32'd1;
      12'h048: return c;
      12'h050: return {16'h0, m_disp};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h000: return "R9";
      12'h008: return "R11";
      12'h020: return "R2";
      12'h030, 12'h034: return "R5";
      12'h038, 12'h03C: return "R6";
      12'h040: return "R3";
      12'h048: return "R8";
      12'h050: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model_reset();
    m_led = '0; m_lock = '0; m_flags = '0; m_level = '0; m_disp = 16'h1F00; m_card = '0;
  endtask

  // write one word, update model, check reset request pulses (R4)
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           input logic cd, input logic cw);
    logic exp_a, exp_b, acc;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d; card_det = cd; card_wp = cw;
    @(posedge clk);
    acc   = (a == 12'h040) && (m_lock == 16'hA05F);
    exp_a = acc && d[8];
    exp_b = acc && d[2];
    case (a)
      12'h008: m_led = d[7:0];
      12'h020: m_lock = (d == 32'h0000A05F) ? 16'hA05F : (d[15:0] & 16'h7FFF);
      12'h030: m_flags = m_flags | d;
      12'h034: m_flags = m_flags & ~d;
      12'h038: m_nv = m_nv | d;
      12'h03C: m_nv = m_nv & ~d;
      12'h040: if (acc) m_level = d;
      12'h050: m_disp = (m_disp & 16'h3F00) | (d[15:0] & ~16'h3F00);
      default: ;
    endcase
    m_card = {cw, cd};
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 variant A pulse", {31'h0, req_a}, {31'h0, exp_a});
    chk("R4 variant B pulse", {31'h0, req_b}, {31'h0, exp_b});
    chk("R11 led_o", {24'h0, led_a}, {24'h0, m_led});
    chk("R7 mux_sel_o", {30'h0, mux_a}, {30'h0, m_disp[1:0]});
  endtask

  task automatic bus_check(input logic [11:0] a);
    bus_addr = a; bus_wr = 1'b0;
    #1;
    chk(req_of(a), rd_a, exp_read(a, 1'b0));
    chk(req_of(a), rd_b, exp_read(a, 1'b1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [11:0] OFS_LIST [13] = '{12'h000, 12'h004, 12'h008, 12'h020, 12'h030,
    12'h034, 12'h038, 12'h03C, 12'h040, 12'h044, 12'h048, 12'h050, 12'h07C};

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; card_det = 1'b0; card_wp = 1'b0;
    model_reset();
    m_nv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 req", {30'h0, req_b, req_a}, 32'h0);
    chk("R1 led", {24'h0, led_a}, 32'h0);
    chk("R1 mux", {30'h0, mux_a}, 32'h0);
    bus_check(12'h050);
    bus_check(12'h020);
    bus_check(12'h030);
    bus_check(12'h040);
    bus_check(12'h000);
    bus_check(12'h044);

    // clear the retained word (R6)
    bus_write(12'h03C, 32'hFFFF_FFFF, 1'b0, 1'b0);
    bus_check(12'h038);

    // R2 near-miss key and exact key
    bus_write(12'h020, 32'hFFFF_A05F, 1'b0, 1'b0);
    bus_check(12'h020);
    bus_write(12'h040, 32'h0000_0104, 1'b0, 1'b0);  // R3 locked: ignored
    bus_check(12'h040);
    bus_write(12'h020, 32'h0000_A05F, 1'b0, 1'b0);
    bus_check(12'h020);
    bus_write(12'h040, 32'h0000_0100, 1'b0, 1'b0);  // R4 variant A trigger only
    bus_check(12'h040);
    bus_write(12'h040, 32'h0000_0004, 1'b0, 1'b0);  // R4 variant B trigger only
    bus_write(12'h020, 32'h0000_0001, 1'b0, 1'b0);  // R2 re-lock
    bus_write(12'h040, 32'h0000_0104, 1'b0, 1'b0);  // R3 ignored again
    bus_check(12'h040);

    // R7 read-only field
    bus_write(12'h050, 32'hFFFF_C0FF, 1'b0, 1'b0);
    bus_check(12'h050);
    bus_write(12'h050, 32'h0000_0002, 1'b0, 1'b0);
    bus_check(12'h050);

    // R8 card pins, both positions
    bus_write(12'h004, 32'hFFFF_FFFF, 1'b0, 1'b1);  // R10 ignored write
    bus_check(12'h048);
    bus_check(12'h004);
    bus_write(12'h07C, 32'h1234_5678, 1'b1, 1'b0);
    bus_check(12'h048);
    bus_check(12'h07C);
    bus_write(12'h000, 32'hFFFF_FFFF, 1'b1, 1'b1);  // R9 ignored write
    bus_check(12'h000);
    bus_check(12'h048);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = OFS_LIST[$urandom % 13];
      d = $urandom;
      if (a == 12'h020 && ($urandom % 2 == 0)) d = 32'h0000_A05F;
      if (a == 12'h040 && ($urandom % 2 == 0)) d = d | 32'h0000_0104;
      bus_write(a, d, 1'($urandom), 1'($urandom));
      bus_check(a);
      bus_check(OFS_LIST[$urandom % 13]);
    end

    // R6 retained word survives reset, R1 after mid-run reset
    bus_write(12'h03C, 32'hFFFF_FFFF, 1'b0, 1'b0);
    bus_write(12'h038, 32'h5A5A_0000, 1'b0, 1'b0);
    bus_write(12'h008, 32'h0000_00AA, 1'b0, 1'b0);
    bus_write(12'h030, 32'h0000_F00F, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    bus_check(12'h038);
    bus_check(12'h030);
    bus_check(12'h008);
    bus_check(12'h050);
    chk("R1 led after reset", {24'h0, led_b}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule